// File: doc/BRIEF.md
# Serial Command Periphery Controller

This block sits at the edge of a pixel-array chip and turns a one-pin serial command stream into control of the array. Command bits arrive most significant bit first, one per clock in which the bit-valid input is high, and fill a 14-bit command word. When the word is complete it is decoded and executed. There are four operations: a column readout, a per-pixel configuration write, a write of one global configuration register, and an array reset. Readout and configuration act on a column group of 1, 2 or 4 adjacent columns, or on every column.

While an operation runs, the controller drives a column mask and an array mode. It also picks the clock that reaches the array. The readout clock is used for readout and configuration, and the counting clock while the shutter is open. Otherwise no clock is sent. Whenever the source changes, one cycle with both clocks off comes first. Both source clocks are represented by gate enables, and the clock-tree cells that use them are outside the block. The shutter and analog power-off pins pass through one register stage. The test-pulse pin passes through only once a configuration write has finished since the last array reset.

Top module: `cmd_periph_ctrl`

## Requirements
- R1: Serial bits are shifted in most significant bit first on cycles with `cmd_bit_vld` high. The command takes effect on the outputs after the clock edge that follows the edge capturing its 14th bit.
- R2: Command word layout: bits 13:11 opcode (0 no-op, 1 readout, 2 configuration write, 3 global register write, 4 array reset, 5 to 7 no-op), bits 10:9 group code, bits 8:3 start column, bits 2:0 unused. For opcode 3, bits 10:8 are the register index and bits 7:0 are the value.
- R3: Group code 0, 1 and 2 selects 1, 2 and 4 columns from the start column upward, clipped at the last column. Group code 3 selects all columns regardless of the start column. `col_mask` bit c is high for each selected column c.
- R4: A readout sets `arr_mode` to 1 for RO_LEN cycles and a configuration write sets it to 2 for CFG_LEN cycles, with `col_mask` held. Afterwards `arr_mode` returns to 0 and `col_mask` to all zeros.
- R5: Serial input received while a readout or configuration write is in progress, or in the cycle after a command completes, is discarded and does not count toward the next command.
- R6: A global write stores the 8-bit value in register index i, which appears at `glob_regs[8*i+7:8*i]`. All registers reset to zero.
- R7: An array reset command raises `arr_rst` for exactly one cycle and clears the configured state.
- R8: The array clock is the readout clock (`clk_ro_en`) while `arr_mode` is nonzero. Otherwise it is the counting clock (`clk_cnt_en`) while the registered shutter is high, and otherwise neither. The two enables are never high together.
- R9: A change from one clock source to the other passes through exactly one cycle with both enables low. A change from no clock to a clock takes one cycle.
- R10: `shutter_out` and `pwroff_out` follow their pins one cycle later. `tp_out` follows `tp_pin` one cycle later, but only while a configuration write has completed since reset or the last array reset.
- R11: After reset, every output is low and the mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_bit | input | 1 | Serial command data |
| cmd_bit_vld | input | 1 | Qualifies cmd_bit in this cycle |
| shutter_pin | input | 1 | External shutter request |
| pwroff_pin | input | 1 | External analog power-off request |
| tp_pin | input | 1 | External test-pulse request |
| arr_mode | output | 2 | 0 idle, 1 readout, 2 configuration |
| col_mask | output | NCOL | Selected columns of the running operation |
| arr_rst | output | 1 | One-cycle array reset pulse |
| clk_cnt_en | output | 1 | Forward counting clock to array |
| clk_ro_en | output | 1 | Forward readout clock to array |
| shutter_out | output | 1 | Registered shutter to array |
| pwroff_out | output | 1 | Registered analog power-off |
| tp_out | output | 1 | Gated registered test pulse |
| glob_regs | output | NREG*REG_W | Global configuration registers, index 0 in the low byte |

## Verification
Directed cases place column groups at the top edge of the array and use the full-chip code with a nonzero start column. These separate correct clipping from wraparound, and show that the start field is ignored when every column is selected. Random commands with random group codes, start columns, register indexes and values are checked against masks and a register model computed in the bench. This exposes misplaced fields or a reversed bit order. Junk bits sent during a readout show whether busy-time input leaks into the next command. Changing the clock while the shutter is open, compared with while it is closed, separates the dead-cycle path from the direct path.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int CMD_W = 14;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_READ = 3'd1,
    OP_CFG  = 3'd2,
    OP_GLOB = 3'd3,
    OP_ARST = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    AM_IDLE = 2'd0,
    AM_READ = 2'd1,
    AM_CFG  = 2'd2
  } amode_e;

  typedef enum logic [1:0] {
    CK_OFF = 2'd0,
    CK_CNT = 2'd1,
    CK_RO  = 2'd2
  } cksrc_e;
endpackage

// File: rtl/cpc_deser.sv
module cpc_deser
  import cpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_i,
  input  logic             vld_i,
  input  logic             hold_i,
  output logic [CMD_W-1:0] word_o,
  output logic             rdy_o
);
  localparam int CNT_W = $clog2(CMD_W + 1);

  logic [CMD_W-1:0] shreg;
  logic [CNT_W-1:0] nbits;
  logic             take;

  assign take = vld_i && !hold_i && !rdy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      nbits <= '0;
      rdy_o <= 1'b0;
    end else begin
      rdy_o <= 1'b0;
      if (take) begin
        shreg <= {shreg[CMD_W-2:0], bit_i};
        if (nbits == CNT_W'(CMD_W - 1)) begin
          nbits <= '0;
          rdy_o <= 1'b1;
        end else begin
          nbits <= nbits + 1'b1;
        end
      end
    end
  end

  assign word_o = shreg;
endmodule

// File: rtl/cpc_seq.sv
module cpc_seq
  import cpc_pkg::*;
#(
  parameter int NCOL   = 64,
  parameter int NREG   = 8,
  parameter int REG_W  = 8,
  parameter int RO_LEN = 16,
  parameter int CFG_LEN = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CMD_W-1:0]      word_i,
  input  logic                  rdy_i,
  output amode_e                mode_o,
  output logic [NCOL-1:0]       mask_o,
  output logic                  arr_rst_o,
  output logic                  busy_o,
  output logic                  cfg_done_o,
  output logic [NREG*REG_W-1:0] glob_o
);
  localparam int LEN_MAX = (RO_LEN > CFG_LEN) ? RO_LEN : CFG_LEN;
  localparam int LEN_W   = $clog2(LEN_MAX + 1);

  op_e             op;
  logic [1:0]      grp;
  logic [5:0]      start;
  logic [2:0]      ridx;
  logic [7:0]      rval;
  logic [NCOL-1:0] mask_n;
  logic [LEN_W-1:0] left;
  int              gsize;

  assign op    = op_e'(word_i[13:11]);
  assign grp   = word_i[10:9];
  assign start = word_i[8:3];
  assign ridx  = word_i[10:8];
  assign rval  = word_i[7:0];

  always_comb begin
    case (grp)
      2'd0:    gsize = 1;
      2'd1:    gsize = 2;
      2'd2:    gsize = 4;
      default: gsize = NCOL;
    endcase
    for (int c = 0; c < NCOL; c++) begin
      mask_n[c] = (grp == 2'd3) ||
                  ((c >= int'(start)) && (c < int'(start) + gsize));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o     <= AM_IDLE;
      mask_o     <= '0;
      arr_rst_o  <= 1'b0;
      cfg_done_o <= 1'b0;
      left       <= '0;
    end else begin
      arr_rst_o <= 1'b0;
      if (mode_o != AM_IDLE) begin
        if (left == '0) begin
          if (mode_o == AM_CFG) cfg_done_o <= 1'b1;
          mode_o <= AM_IDLE;
          mask_o <= '0;
        end else begin
          left <= left - 1'b1;
        end
      end else if (rdy_i) begin
        case (op)
          OP_READ: begin
            mode_o <= AM_READ;
            mask_o <= mask_n;
            left   <= LEN_W'(RO_LEN - 1);
          end
          OP_CFG: begin
            mode_o <= AM_CFG;
            mask_o <= mask_n;
            left   <= LEN_W'(CFG_LEN - 1);
          end
          OP_ARST: begin
            arr_rst_o  <= 1'b1;
            cfg_done_o <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      logic [REG_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) begin
          r <= '0;
        end else if (rdy_i && mode_o == AM_IDLE && op == OP_GLOB &&
                     int'(ridx) == gi) begin
          r <= REG_W'(rval);
        end
      end
      assign glob_o[gi*REG_W +: REG_W] = r;
    end
  endgenerate

  assign busy_o = (mode_o != AM_IDLE);
endmodule

// File: rtl/cpc_clksel.sv
module cpc_clksel
  import cpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cksrc_e req_i,
  output logic   en_cnt_o,
  output logic   en_ro_o
);
  cksrc_e cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= CK_OFF;
    end else if (cur != req_i) begin
      if (cur != CK_OFF) cur <= CK_OFF;
      else               cur <= req_i;
    end
  end

  assign en_cnt_o = (cur == CK_CNT);
  assign en_ro_o  = (cur == CK_RO);
endmodule

// File: rtl/cmd_periph_ctrl.sv
module cmd_periph_ctrl
  import cpc_pkg::*;
#(
  parameter int NCOL    = 64,
  parameter int NREG    = 8,
  parameter int REG_W   = 8,
  parameter int RO_LEN  = 16,
  parameter int CFG_LEN = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_bit,
  input  logic                  cmd_bit_vld,
  input  logic                  shutter_pin,
  input  logic                  pwroff_pin,
  input  logic                  tp_pin,
  output logic [1:0]            arr_mode,
  output logic [NCOL-1:0]       col_mask,
  output logic                  arr_rst,
  output logic                  clk_cnt_en,
  output logic                  clk_ro_en,
  output logic                  shutter_out,
  output logic                  pwroff_out,
  output logic                  tp_out,
  output logic [NREG*REG_W-1:0] glob_regs
);
  logic [CMD_W-1:0] word;
  logic             rdy;
  logic             busy;
  logic             cfg_done;
  amode_e           mode;
  cksrc_e           req;

  cpc_deser u_deser (
    .clk    (clk),
    .rst    (rst),
    .bit_i  (cmd_bit),
    .vld_i  (cmd_bit_vld),
    .hold_i (busy),
    .word_o (word),
    .rdy_o  (rdy)
  );

  cpc_seq #(
    .NCOL    (NCOL),
    .NREG    (NREG),
    .REG_W   (REG_W),
    .RO_LEN  (RO_LEN),
    .CFG_LEN (CFG_LEN)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .word_i     (word),
    .rdy_i      (rdy),
    .mode_o     (mode),
    .mask_o     (col_mask),
    .arr_rst_o  (arr_rst),
    .busy_o     (busy),
    .cfg_done_o (cfg_done),
    .glob_o     (glob_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shutter_out <= 1'b0;
      pwroff_out  <= 1'b0;
      tp_out      <= 1'b0;
    end else begin
      shutter_out <= shutter_pin;
      pwroff_out  <= pwroff_pin;
      tp_out      <= tp_pin && cfg_done;
    end
  end

  always_comb begin
    if (mode != AM_IDLE) req = CK_RO;
    else if (shutter_out) req = CK_CNT;
    else req = CK_OFF;
  end

  cpc_clksel u_clksel (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req),
    .en_cnt_o (clk_cnt_en),
    .en_ro_o  (clk_ro_en)
  );

  assign arr_mode = mode;
endmodule

// File: rtl/cmd_periph_chk.sv
module cmd_periph_chk #(
  parameter int NCOL = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      arr_mode,
  input logic [NCOL-1:0] col_mask,
  input logic            arr_rst,
  input logic            clk_cnt_en,
  input logic            clk_ro_en,
  input logic            tp_pin,
  input logic            tp_out
);
  AST_CLK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(clk_cnt_en && clk_ro_en)); // R8
  AST_DEAD_CNT_RO: assert property (@(posedge clk) disable iff (rst)
    clk_cnt_en |=> !clk_ro_en); // R9
  AST_DEAD_RO_CNT: assert property (@(posedge clk) disable iff (rst)
    clk_ro_en |=> !clk_cnt_en); // R9
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    arr_rst |=> !arr_rst); // R7
  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (arr_mode == 2'd0) |-> (col_mask == '0)); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    arr_mode != 2'd3); // R4
  AST_TP_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(tp_out) |-> $past(tp_pin)); // R10
endmodule

bind cmd_periph_ctrl cmd_periph_chk #(.NCOL(NCOL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .arr_mode   (arr_mode),
  .col_mask   (col_mask),
  .arr_rst    (arr_rst),
  .clk_cnt_en (clk_cnt_en),
  .clk_ro_en  (clk_ro_en),
  .tp_pin     (tp_pin),
  .tp_out     (tp_out)
);

// File: tb/cmd_periph_ctrl_bench.sv
module cmd_periph_ctrl_bench;
  localparam int NCOL = 64;
  localparam int NREG = 8;
  localparam int REG_W = 8;
  localparam int RO_LEN = 16;
  localparam int CFG_LEN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_bit = 1'b0, cmd_bit_vld = 1'b0;
  logic shutter_pin = 1'b0, pwroff_pin = 1'b0, tp_pin = 1'b0;
  logic [1:0] arr_mode;
  logic [NCOL-1:0] col_mask;
  logic arr_rst, clk_cnt_en, clk_ro_en, shutter_out, pwroff_out, tp_out;
  logic [NREG*REG_W-1:0] glob_regs;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [NREG*REG_W-1:0] gmodel = '0;

  always #4 clk = ~clk;

  cmd_periph_ctrl #(.NCOL(NCOL), .NREG(NREG), .REG_W(REG_W),
                    .RO_LEN(RO_LEN), .CFG_LEN(CFG_LEN)) u_cmd_periph_ctrl (
    .clk(clk), .rst(rst), .cmd_bit(cmd_bit), .cmd_bit_vld(cmd_bit_vld),
    .shutter_pin(shutter_pin), .pwroff_pin(pwroff_pin), .tp_pin(tp_pin),
    .arr_mode(arr_mode), .col_mask(col_mask), .arr_rst(arr_rst),
    .clk_cnt_en(clk_cnt_en), .clk_ro_en(clk_ro_en), .shutter_out(shutter_out),
    .pwroff_out(pwroff_out), .tp_out(tp_out), .glob_regs(glob_regs));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_mask(input int grp, input int start);
    logic [63:0] m = '0;
    int sz = (grp == 3) ? NCOL : (1 << grp);
    for (int c = 0; c < NCOL; c++)
      if (grp == 3 || (c >= start && c < start + sz)) m[c] = 1'b1;
    return m;
  endfunction

  function automatic logic [13:0] mk(input int op, input int grp, input int start);
    return {op[2:0], grp[1:0], start[5:0], 3'b000};
  endfunction

  function automatic logic [13:0] mkg(input int idx, input int val);
    return {3'd3, idx[2:0], val[7:0]};
  endfunction

  // Returns at the sample point right after the executing edge (R1).
  task automatic send(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk);
      cmd_bit = w[i];
      cmd_bit_vld = 1'b1;
    end
    @(negedge clk);
    cmd_bit_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_op(input int op, input int grp, input int start, input string tag);
    int n = 0;
    int len = (op == 1) ? RO_LEN : CFG_LEN;
    send(mk(op, grp, start));
    chk(arr_mode == op[1:0], tag, 64'(arr_mode), 64'(op));
    chk(col_mask == exp_mask(grp, start), "R3 mask", col_mask, exp_mask(grp, start));
    while (arr_mode != 2'd0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == len, "R4 duration", 64'(n), 64'(len));
    chk(col_mask == '0, "R4 mask cleared", col_mask, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(arr_mode == 0 && col_mask == '0 && !arr_rst && !clk_cnt_en && !clk_ro_en
        && !tp_out && glob_regs == '0, "R11 reset", {arr_mode, col_mask[61:0]}, 64'd0);

    // R1 R2 R3 R4 readout, top-edge clipping, with clock timing R8 R9
    send(mk(1, 2, 62));
    chk(arr_mode == 1, "R1 execute timing", 64'(arr_mode), 64'd1);
    chk(col_mask == exp_mask(2, 62), "R3 clip", col_mask, exp_mask(2, 62));
    chk(!clk_ro_en, "R9 off to ro latency", 64'(clk_ro_en), 64'd0);
    @(negedge clk);
    chk(clk_ro_en && !clk_cnt_en, "R8 ro clock", 64'(clk_ro_en), 64'd1);
    // R5 junk bits during busy
    for (int i = 0; i < 10; i++) begin
      cmd_bit = 1'($urandom);
      cmd_bit_vld = 1'b1;
      @(negedge clk);
    end
    cmd_bit_vld = 1'b0;
    while (arr_mode != 0) @(negedge clk);
    send(mkg(5, 8'hA7));
    gmodel[5*8 +: 8] = 8'hA7;
    chk(glob_regs == gmodel, "R5 busy input ignored / R6", glob_regs, gmodel);

    // R3 full chip ignores start
    run_op(1, 3, 17, "R4 readout full");
    run_op(2, 0, 63, "R4 cfg single top");

    // R8 R9 shutter: counting clock, then dead cycle to readout
    shutter_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk(clk_cnt_en && !clk_ro_en && shutter_out, "R8 count clock", 64'(clk_cnt_en), 64'd1);
    send(mk(1, 1, 4));
    chk(clk_cnt_en, "R9 cnt held at exec", 64'(clk_cnt_en), 64'd1);
    @(negedge clk);
    chk(!clk_cnt_en && !clk_ro_en, "R9 dead cycle", {clk_cnt_en, clk_ro_en}, 64'd0);
    @(negedge clk);
    chk(clk_ro_en, "R9 ro after dead", 64'(clk_ro_en), 64'd1);
    while (arr_mode != 0) @(negedge clk);
    @(negedge clk);
    chk(!clk_cnt_en && !clk_ro_en, "R9 dead back", {clk_cnt_en, clk_ro_en}, 64'd0);
    @(negedge clk);
    chk(clk_cnt_en, "R8 cnt restored", 64'(clk_cnt_en), 64'd1);
    shutter_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(!clk_cnt_en && !clk_ro_en, "R8 no clock", {clk_cnt_en, clk_ro_en}, 64'd0);

    // R10 passthrough and test pulse gating (configured by cfg run above)
    pwroff_pin = 1'b1;
    tp_pin = 1'b1;
    @(negedge clk);
    chk(pwroff_out, "R10 pwroff", 64'(pwroff_out), 64'd1);
    chk(tp_out, "R10 tp after config", 64'(tp_out), 64'd1);
    // R7 array reset pulse clears configured state
    send(mk(4, 0, 0));
    chk(arr_rst, "R7 pulse high", 64'(arr_rst), 64'd1);
    @(negedge clk);
    chk(!arr_rst, "R7 pulse one cycle", 64'(arr_rst), 64'd0);
    chk(!tp_out, "R7 R10 tp blocked after reset", 64'(tp_out), 64'd0);
    tp_pin = 1'b0;
    pwroff_pin = 1'b0;
    chk(glob_regs == gmodel, "R7 globals kept", glob_regs, gmodel);

    // R2 no-op opcode changes nothing
    send(mk(6, 3, 0));
    @(negedge clk);
    chk(arr_mode == 0 && glob_regs == gmodel, "R2 spare opcode", glob_regs, gmodel);

    // Random mix R2 R3 R6
    for (int it = 0; it < 24; it++) begin
      int k = $urandom_range(0, 2);
      if (k == 2) begin
        int idx = $urandom_range(0, 7);
        int val = $urandom_range(0, 255);
        send(mkg(idx, val));
        gmodel[idx*8 +: 8] = val[7:0];
        chk(glob_regs == gmodel, "R6 random global", glob_regs, gmodel);
      end else begin
        run_op(k + 1, $urandom_range(0, 3), $urandom_range(0, 63), "R2 random op");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule